// File: doc/BRIEF.md
# GPIO Output, Enable and Event Flag Register Block

This block is a register slave for 32 digital I/O lines. A single 32-bit output value register decides the level of every pin. Software can change it in four ways: a plain write of the whole word; atomic set, clear and toggle masks that touch only the bits written as 1; and eight alias words. Each alias word covers four neighbouring pins, and each pin sits in the lowest bit of its own byte lane, so every pin can be reached with a byte store. A separate per-pin drive-enable register gates what reaches the pads. The pad levels pass through a two-stage synchronizer before they can be read.

Every pin also has a sticky event flag. An external edge detector raises it with a one-cycle pulse, and software clears it by writing a 1 to the bit. The OR of all flags drives an interrupt line. The bus is a single-cycle interface. A write takes effect on the clock edge on which it is presented. Read data is a combinational function of the address.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After reset the output value, drive-enable and event flag registers are 0, and pad_out, pad_oe and irq are 0.
- R2: The word at offset 0x80 is the output value register: a write stores all 32 bits, bit n controls pin n, and a read returns the stored value.
- R3: Writing to offset 0x90 sets every output bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: Writing to offset 0xA0 clears every output bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: Writing to offset 0xB0 inverts every output bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: Alias word k sits at offset 4*k, for k from 0 to 7. A write to it loads pin 4k+j from write-data bit 8*j, for j from 0 to 3. The other 28 bits of the word are ignored, and reading the word returns 0.
- R7: The word at offset 0xD0 is the read/write drive-enable register. pad_oe equals it, and pad_out bit n equals output bit n when enable bit n is 1 and is 0 otherwise.
- R8: Reading offset 0xC0 returns the pin_in levels after two register stages. A change of pin_in is not visible after one clock edge and is visible after two. Writes to 0xC0 change nothing.
- R9: An evt_pulse bit sets its flag at offset 0xE0. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R10: If an event pulse and a clearing write hit the same flag bit in the same cycle, the flag stays set.
- R11: irq is 1 exactly when at least one event flag is set.
- R12: The set, clear and toggle words read as 0. Every other offset, including any address whose two low bits are not 00, reads as 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| evt_pulse | input | 32 | One-cycle event pulse per pin |
| pad_out | output | 32 | Pad output values, gated by the drive enables |
| pad_oe | output | 32 | Pad drive enables |
| irq | output | 1 | OR of all event flags |

## Verification
The assertions assume that only one register is addressed per cycle. They also assume that bus_addr, bus_wdata, bus_wr and evt_pulse are stable around the sampling clock edge and are at known values once the internal reset is released. The bench drives every input on the falling edge. It keeps the bus idle during the two cycles in which the internal reset is still held after rst_n rises. It issues each write with the strobe high for exactly one rising edge, so every property sees a single, clean access.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_SET   = 8'h90;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'hA0;
  localparam logic [ADDR_W-1:0] OFS_TGL   = 8'hB0;
  localparam logic [ADDR_W-1:0] OFS_IN    = 8'hC0;
  localparam logic [ADDR_W-1:0] OFS_OE    = 8'hD0;
  localparam logic [ADDR_W-1:0] OFS_EVT   = 8'hE0;
  localparam int                ALIAS_SPAN = 32;  // bytes covered by alias words

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_ALIAS,
    SEL_DATA,
    SEL_SET,
    SEL_CLR,
    SEL_TGL,
    SEL_IN,
    SEL_OE,
    SEL_EVT
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if (a[1:0] == 2'b00) begin
      if (int'(a) < ALIAS_SPAN) s = SEL_ALIAS;
      else begin
        case (a)
          OFS_DATA: s = SEL_DATA;
          OFS_SET:  s = SEL_SET;
          OFS_CLR:  s = SEL_CLR;
          OFS_TGL:  s = SEL_TGL;
          OFS_IN:   s = SEL_IN;
          OFS_OE:   s = SEL_OE;
          OFS_EVT:  s = SEL_EVT;
          default:  s = SEL_NONE;
        endcase
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_dout_reg.sv
module gpio_dout_reg #(
  parameter int NPINS        = 32,
  parameter int PINS_PER_WRD = 4,
  parameter int LANE_W       = 8,
  localparam int NALIAS      = NPINS / PINS_PER_WRD,
  localparam int IDX_W       = (NALIAS > 1) ? $clog2(NALIAS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_full,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic             wr_tgl,
  input  logic             wr_alias,
  input  logic [IDX_W-1:0] alias_idx,
  input  logic [31:0]      wdata,
  output logic [NPINS-1:0] dout_q
);
  logic [NPINS-1:0] mask;
  logic [NPINS-1:0] dout_d;
  logic             dout_en;
  logic [NPINS-1:0] alias_sel;
  logic [NPINS-1:0] alias_val;

  assign mask = wdata[NPINS-1:0];

  // each alias word spreads its lane-bit-0 values over four consecutive pins
  for (genvar k = 0; k < NALIAS; k++) begin : g_alias
    for (genvar j = 0; j < PINS_PER_WRD; j++) begin : g_lane
      assign alias_sel[k*PINS_PER_WRD+j] = (alias_idx == IDX_W'(k));
      assign alias_val[k*PINS_PER_WRD+j] = wdata[j*LANE_W];
    end
  end

  assign dout_en = wr_full | wr_set | wr_clr | wr_tgl | wr_alias;

  always_comb begin
    dout_d = dout_q;
    if (wr_full)       dout_d = mask;
    else if (wr_set)   dout_d = dout_q | mask;
    else if (wr_clr)   dout_d = dout_q & ~mask;
    else if (wr_tgl)   dout_d = dout_q ^ mask;
    else if (wr_alias) dout_d = (dout_q & ~alias_sel) | (alias_val & alias_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (dout_en) dout_q <= dout_d;
  end
endmodule

// File: rtl/gpio_evt_flags.sv
module gpio_evt_flags #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] evt_in,
  input  logic             clr_en,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] flags_q,
  output logic             irq
);
  logic [NPINS-1:0] flags_d;
  logic [NPINS-1:0] clr_eff;
  logic             flags_en;

  assign clr_eff  = clr_en ? clr_mask : '0;
  assign flags_en = clr_en | (|evt_in);

  // a new pulse wins over a clear in the same cycle
  always_comb begin
    flags_d = (flags_q & ~clr_eff) | evt_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign irq = |flags_q;
endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  evt_pulse,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  localparam int PINS_PER_WRD = 4;
  localparam int NALIAS       = NPINS / PINS_PER_WRD;
  localparam int IDX_W        = (NALIAS > 1) ? $clog2(NALIAS) : 1;

  logic             rst_sync_n;
  reg_sel_e         sel;
  logic [IDX_W-1:0] alias_idx;
  logic [NPINS-1:0] dout_q;
  logic [NPINS-1:0] oe_q;
  logic [NPINS-1:0] oe_d;
  logic             oe_en;
  logic [NPINS-1:0] flags_q;
  logic [NPINS-1:0] in_q;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  assign sel       = decode_addr(bus_addr);
  assign alias_idx = bus_addr[2 +: IDX_W];

  gpio_dout_reg #(.NPINS(NPINS), .PINS_PER_WRD(PINS_PER_WRD), .LANE_W(8)) u_dout (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_full   (bus_wr && sel == SEL_DATA),
    .wr_set    (bus_wr && sel == SEL_SET),
    .wr_clr    (bus_wr && sel == SEL_CLR),
    .wr_tgl    (bus_wr && sel == SEL_TGL),
    .wr_alias  (bus_wr && sel == SEL_ALIAS),
    .alias_idx (alias_idx),
    .wdata     (bus_wdata),
    .dout_q    (dout_q)
  );

  gpio_evt_flags #(.NPINS(NPINS)) u_evt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt_in   (evt_pulse),
    .clr_en   (bus_wr && sel == SEL_EVT),
    .clr_mask (bus_wdata[NPINS-1:0]),
    .flags_q  (flags_q),
    .irq      (irq)
  );

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(2)) u_in (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pin_in),
    .q     (in_q)
  );

  // drive-enable register
  assign oe_en = bus_wr && (sel == SEL_OE);

  always_comb begin
    oe_d = bus_wdata[NPINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) oe_q <= '0;
    else if (oe_en)  oe_q <= oe_d;
  end

  assign pad_oe  = oe_q;
  assign pad_out = dout_q & oe_q;

  // read path
  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_DATA: bus_rdata = 32'(dout_q);
      SEL_IN:   bus_rdata = 32'(in_q);
      SEL_OE:   bus_rdata = 32'(oe_q);
      SEL_EVT:  bus_rdata = 32'(flags_q);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

module gpio_evt_chk
  import gpio_evt_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [NPINS-1:0] evt_pulse,
  input logic [NPINS-1:0] dout_q,
  input logic [NPINS-1:0] oe_q,
  input logic [NPINS-1:0] flags_q,
  input logic [NPINS-1:0] pad_oe,
  input logic             irq
);
  logic [NPINS-1:0] w;
  logic             wr_unmapped;

  assign w = bus_wdata[NPINS-1:0];
  assign wr_unmapped = bus_wr && ((bus_addr[1:0] != 2'b00) ||
                       ((bus_addr >= 8'h20) && (bus_addr != OFS_DATA) &&
                        (bus_addr != OFS_SET) && (bus_addr != OFS_CLR) &&
                        (bus_addr != OFS_TGL) && (bus_addr != OFS_IN) &&
                        (bus_addr != OFS_OE) && (bus_addr != OFS_EVT)));

  a_r2_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DATA) |=> dout_q == $past(w));

  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_SET) |=> dout_q == ($past(dout_q) | $past(w)));

  a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CLR) |=> dout_q == ($past(dout_q) & ~$past(w)));

  a_r5_tgl_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_TGL) |=> dout_q == ($past(dout_q) ^ $past(w)));

  a_r7_oe_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_OE) |=> pad_oe == $past(w));

  a_r10_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> (flags_q & $past(evt_pulse)) == $past(evt_pulse));

  a_r9_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(evt_pulse)) == '0));

  a_r11_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(evt_pulse) != '0));

  a_r12_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_unmapped && evt_pulse == '0) |=> ($stable(dout_q) && $stable(oe_q) && $stable(flags_q)));
endmodule

bind gpio_evt_ctrl gpio_evt_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .evt_pulse (evt_pulse),
  .dout_q    (dout_q),
  .oe_q      (oe_q),
  .flags_q   (flags_q),
  .pad_oe    (pad_oe),
  .irq       (irq)
);

// File: tb/sim_gpio_evt_ctrl.sv
module sim_gpio_evt_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 100000;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] evt_pulse;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [31:0] exp_dout, exp_oe, exp_flags;
  logic [31:0] seed = 32'h1234_5678;

  gpio_evt_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .evt_pulse(evt_pulse), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int c = 0; c < WDOG_LIMIT; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic chk_regs(input string req);
    logic [31:0] r;
    rd(8'h80, r); chk(req, r, exp_dout);
    rd(8'hD0, r); chk(req, r, exp_oe);
    rd(8'hE0, r); chk(req, r, exp_flags);
    chk(req, pad_out, exp_dout & exp_oe);
    chk(req, pad_oe, exp_oe);
    chk(req, {31'b0, irq}, {31'b0, exp_flags != 0});
  endtask

  function automatic bit mapped(input int o);
    return (o < 32 && o % 4 == 0) || o == 'h80 || o == 'h90 || o == 'hA0 ||
           o == 'hB0 || o == 'hC0 || o == 'hD0 || o == 'hE0;
  endfunction

  initial begin
    logic [31:0] r;
    logic [31:0] w;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0; evt_pulse = '0;
    exp_dout = '0; exp_oe = '0; exp_flags = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk_regs("R1");
    rd(8'hC0, r); chk("R1", r, 32'h0);

    // R2 full-word writes
    for (int i = 0; i < 10; i++) begin
      seed = nxt(seed);
      w = (i == 0) ? 32'hFFFF_FFFF : (i == 1) ? 32'h0 : seed;
      wr(8'h80, w); exp_dout = w;
      rd(8'h80, r); chk("R2", r, exp_dout);
    end

    // R7 drive enables and pad gating
    for (int i = 0; i < 8; i++) begin
      seed = nxt(seed);
      wr(8'h80, seed); exp_dout = seed;
      seed = nxt(seed);
      wr(8'hD0, seed); exp_oe = seed;
      chk_regs("R7");
    end
    wr(8'hD0, 32'hFFFF_FFFF); exp_oe = 32'hFFFF_FFFF;

    // R3 walking set, R4 walking clear
    wr(8'h80, 32'h0); exp_dout = '0;
    for (int n = 0; n < 32; n++) begin
      wr(8'h90, 32'h1 << n); exp_dout |= (32'h1 << n);
      rd(8'h80, r); chk("R3", r, exp_dout);
    end
    for (int n = 0; n < 32; n += 3) begin
      wr(8'hA0, 32'h1 << n); exp_dout &= ~(32'h1 << n);
      rd(8'h80, r); chk("R4", r, exp_dout);
    end
    for (int i = 0; i < 6; i++) begin
      seed = nxt(seed);
      if (i % 2 == 0) begin wr(8'h90, seed); exp_dout |= seed; end
      else begin wr(8'hA0, seed); exp_dout &= ~seed; end
      chk_regs((i % 2 == 0) ? "R3" : "R4");
    end

    // R5 toggles
    for (int i = 0; i < 8; i++) begin
      seed = nxt(seed);
      wr(8'hB0, seed); exp_dout ^= seed;
      rd(8'h80, r); chk("R5", r, exp_dout);
      wr(8'hB0, seed); exp_dout ^= seed;
      rd(8'h80, r); chk("R5", r, exp_dout);
    end

    // R6 alias words, reserved bits set to 1
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < 16; p++) begin
        w = 32'hFEFE_FEFE;
        for (int j = 0; j < 4; j++) w[8*j] = p[j];
        wr(8'(4*k), w);
        for (int j = 0; j < 4; j++) exp_dout[4*k+j] = p[j];
        rd(8'h80, r); chk("R6", r, exp_dout);
        rd(8'(4*k), r); chk("R6", r, 32'h0);
      end
    end

    // R8 synchronized input
    for (int i = 0; i < 8; i++) begin
      logic [31:0] old;
      rd(8'hC0, old);
      seed = nxt(seed);
      pin_in = seed;
      @(negedge clk);
      rd(8'hC0, r); chk("R8", r, old);
      @(negedge clk);
      rd(8'hC0, r); chk("R8", r, seed);
      wr(8'hC0, ~seed);
      rd(8'hC0, r); chk("R8", r, seed);
      chk_regs("R8");
    end

    // R9 per-pin events and clear semantics
    for (int n = 0; n < 32; n++) begin
      evt_pulse = 32'h1 << n;
      @(negedge clk);
      evt_pulse = '0;
      exp_flags |= (32'h1 << n);
      rd(8'hE0, r); chk("R9", r, exp_flags);
    end
    wr(8'hE0, 32'h0);
    chk_regs("R9");
    seed = nxt(seed);
    wr(8'hE0, seed); exp_flags &= ~seed;
    chk_regs("R9");

    // R10 pulse and clear on the same bits in one cycle
    evt_pulse = 32'h8000_0101;
    bus_wr = 1'b1; bus_addr = 8'hE0; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_wr = 1'b0; evt_pulse = '0;
    exp_flags = 32'h8000_0101;
    chk_regs("R10");

    // R11 irq follows the flags
    wr(8'hE0, 32'h8000_0001); exp_flags = 32'h0000_0100;
    chk_regs("R11");
    wr(8'hE0, 32'h0000_0100); exp_flags = '0;
    chk_regs("R11");

    // R12 write-only and unmapped offsets
    wr(8'h80, 32'h5A5A_3C3C); exp_dout = 32'h5A5A_3C3C;
    rd(8'h90, r); chk("R12", r, 32'h0);
    rd(8'hA0, r); chk("R12", r, 32'h0);
    rd(8'hB0, r); chk("R12", r, 32'h0);
    evt_pulse = 32'h0000_0010; @(negedge clk); evt_pulse = '0;
    exp_flags = 32'h0000_0010;
    for (int o = 0; o < 256; o++) begin
      if (!mapped(o)) begin
        wr(8'(o), 32'hFFFF_FFFF);
        rd(8'(o), r); chk("R12", r, 32'h0);
        if (o % 16 == 1) chk_regs("R12");
      end
    end
    chk_regs("R12");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule